// File: doc/BRIEF.md
# Register Bank with Alternate-Pair Exchange

This block is the register store of an 8-bit processor core. It keeps an accumulator and a flag register, each with a second copy held in an alternate bank, and two 16-bit pointer registers. The rest of the core reads the active accumulator, flags and both pointers on dedicated output ports, and writes each of them through its own enable and data pair. Every access goes through the current name mapping.

The block also decodes two single-byte exchange opcodes. Opcode `0xEB` trades the two pointer registers. Opcode `0x08` trades the accumulator and the flag register, as one unit, with their alternates. No data is copied. Each exchange toggles a one-bit bank select that remaps names onto storage, and the flip is committed at the end of a single machine cycle of four clock states. A small sequencer reports which clock state is in progress and marks the last one.

Top module: `regbank_xchg`

## Requirements
- R1: After reset the accumulator, flags and both pointers read zero, `busy` is 0, `tstate` is 0, and both bank selects are cleared so the main copies are active. `tstate` reads 0 whenever `busy` is 0.
- R2: Opcode `0xEB` offered while idle swaps the values on `ptr_x` and `ptr_y` and leaves the accumulator and flags unchanged.
- R3: Opcode `0x08` offered while idle swaps the accumulator and the flags together with their alternate copies and leaves both pointers unchanged. No flag value is computed or altered by either exchange.
- R4: An opcode is accepted on a clock edge where `op_valid` is 1 and `busy` is 0. After it is accepted, `busy` is 1 for exactly 4 cycles with `tstate` counting 0, 1, 2, 3. `xchg_done` is 1 only in the cycle with `tstate` = 3, and the swapped values appear in the cycle that follows.
- R5: While an exchange is in progress and no write is made, all four register outputs keep their old values.
- R6: Each write goes to the storage that the register name currently maps to. A value written to the accumulator after a `0x08` exchange lands in the alternate copy.
- R7: Issuing the same exchange twice restores the original contents on every output.
- R8: Any opcode other than `0xEB` and `0x08`, and any opcode offered while `busy` is 1, is ignored. It starts no cycle and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode offered this cycle |
| op_code | input | 8 | Opcode byte |
| wr_acc_en | input | 1 | Write the active accumulator |
| wr_acc_data | input | 8 | Accumulator write data |
| wr_flg_en | input | 1 | Write the active flag register |
| wr_flg_data | input | 8 | Flag write data |
| wr_px_en | input | 1 | Write the pointer currently named X |
| wr_px_data | input | 16 | Pointer X write data |
| wr_py_en | input | 1 | Write the pointer currently named Y |
| wr_py_data | input | 16 | Pointer Y write data |
| acc | output | 8 | Active accumulator |
| flags | output | 8 | Active flag register |
| ptr_x | output | 16 | Pointer X |
| ptr_y | output | 16 | Pointer Y |
| busy | output | 1 | Exchange machine cycle in progress |
| tstate | output | 2 | Current clock state of the machine cycle |
| xchg_done | output | 1 | Last clock state; the swap commits at its end |

## Verification
The hardest state to reach is one where the alternate accumulator and flags hold values that differ from the main ones. Only then does a swap show a change that can be observed. The alternate copies can only be loaded by writing after a `0x08` exchange, so the vector table mixes writes with both opcodes. The bank selects therefore end up in all four combinations. Directed tests then offer an opcode during a running exchange, and repeat an exchange so the earlier contents must come back.

// File: rtl/regbank_xchg_pkg.sv
package regbank_xchg_pkg;

    typedef enum logic [1:0] {
        XK_NONE = 2'd0,
        XK_PAIR = 2'd1,
        XK_ACCF = 2'd2
    } xchg_kind_e;

endpackage

// File: rtl/xchg_decode.sv
module xchg_decode
    import regbank_xchg_pkg::*;
#(
    parameter int          OP_W     = 8,
    parameter logic [7:0]  OPC_PAIR = 8'hEB,
    parameter logic [7:0]  OPC_ACCF = 8'h08
) (
    input  logic [OP_W-1:0] op_code,
    output xchg_kind_e      kind
);

    always_comb begin
        if (op_code == OP_W'(OPC_PAIR)) begin
            kind = XK_PAIR;
        end else if (op_code == OP_W'(OPC_ACCF)) begin
            kind = XK_ACCF;
        end else begin
            kind = XK_NONE;
        end
    end

endmodule

// File: rtl/xchg_tseq.sv
module xchg_tseq
    import regbank_xchg_pkg::*;
#(
    parameter int T_STATES = 4,
    localparam int TCW     = (T_STATES > 1) ? $clog2(T_STATES) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  xchg_kind_e     start_kind,
    output logic           busy,
    output logic [TCW-1:0] tstate,
    output logic           last,
    output logic           commit_pair,
    output logic           commit_accf
);

    localparam logic [TCW-1:0] T_LAST = TCW'(T_STATES - 1);

    typedef struct packed {
        logic           busy;
        logic [TCW-1:0] tcnt;
        xchg_kind_e     kind;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (start && (start_kind != XK_NONE)) begin
                seq_d.busy = 1'b1;
                seq_d.tcnt = '0;
                seq_d.kind = start_kind;
            end
        end else if (seq_q.tcnt == T_LAST) begin
            seq_d.busy = 1'b0;
            seq_d.tcnt = '0;
            seq_d.kind = XK_NONE;
        end else begin
            seq_d.tcnt = seq_q.tcnt + TCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{busy: 1'b0, tcnt: '0, kind: XK_NONE};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy        = seq_q.busy;
    assign tstate      = seq_q.tcnt;
    assign last        = seq_q.busy && (seq_q.tcnt == T_LAST);
    assign commit_pair = last && (seq_q.kind == XK_PAIR);
    assign commit_accf = last && (seq_q.kind == XK_ACCF);

endmodule

// File: rtl/xchg_banks.sv
module xchg_banks #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 16,
    parameter int BANKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc_en,
    input  logic [DATA_W-1:0] wr_acc_data,
    input  logic              wr_flg_en,
    input  logic [DATA_W-1:0] wr_flg_data,
    input  logic              wr_px_en,
    input  logic [PTR_W-1:0]  wr_px_data,
    input  logic              wr_py_en,
    input  logic [PTR_W-1:0]  wr_py_data,
    input  logic              flip_pair,
    input  logic              flip_accf,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] flags,
    output logic [PTR_W-1:0]  ptr_x,
    output logic [PTR_W-1:0]  ptr_y
);

    typedef struct packed {
        logic                         sel_a;
        logic                         sel_p;
        logic [BANKS-1:0][DATA_W-1:0] acc_m;
        logic [BANKS-1:0][DATA_W-1:0] flg_m;
        logic [BANKS-1:0][PTR_W-1:0]  ptr_m;
    } bank_t;

    bank_t bk_d, bk_q;

    // Writes use the mapping in force this cycle; a flip takes effect next cycle.
    always_comb begin
        bk_d = bk_q;
        for (int b = 0; b < BANKS; b++) begin
            if (wr_acc_en && (b[0] == bk_q.sel_a)) bk_d.acc_m[b] = wr_acc_data;
            if (wr_flg_en && (b[0] == bk_q.sel_a)) bk_d.flg_m[b] = wr_flg_data;
            if (wr_px_en  && (b[0] == bk_q.sel_p)) bk_d.ptr_m[b] = wr_px_data;
            if (wr_py_en  && (b[0] != bk_q.sel_p)) bk_d.ptr_m[b] = wr_py_data;
        end
        if (flip_pair) bk_d.sel_p = ~bk_q.sel_p;
        if (flip_accf) bk_d.sel_a = ~bk_q.sel_a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign acc   = bk_q.acc_m[bk_q.sel_a];
    assign flags = bk_q.flg_m[bk_q.sel_a];
    assign ptr_x = bk_q.ptr_m[bk_q.sel_p];
    assign ptr_y = bk_q.ptr_m[~bk_q.sel_p];

endmodule

// File: rtl/regbank_xchg.sv
module regbank_xchg
    import regbank_xchg_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter int         PTR_W    = 16,
    parameter int         OP_W     = 8,
    parameter int         T_STATES = 4,
    parameter logic [7:0] OPC_PAIR = 8'hEB,
    parameter logic [7:0] OPC_ACCF = 8'h08,
    localparam int        TCW      = (T_STATES > 1) ? $clog2(T_STATES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              wr_acc_en,
    input  logic [DATA_W-1:0] wr_acc_data,
    input  logic              wr_flg_en,
    input  logic [DATA_W-1:0] wr_flg_data,
    input  logic              wr_px_en,
    input  logic [PTR_W-1:0]  wr_px_data,
    input  logic              wr_py_en,
    input  logic [PTR_W-1:0]  wr_py_data,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] flags,
    output logic [PTR_W-1:0]  ptr_x,
    output logic [PTR_W-1:0]  ptr_y,
    output logic              busy,
    output logic [TCW-1:0]    tstate,
    output logic              xchg_done
);

    xchg_kind_e dec_kind;
    logic       commit_pair;
    logic       commit_accf;

    xchg_decode #(
        .OP_W     (OP_W),
        .OPC_PAIR (OPC_PAIR),
        .OPC_ACCF (OPC_ACCF)
    ) u_dec (
        .op_code (op_code),
        .kind    (dec_kind)
    );

    xchg_tseq #(
        .T_STATES (T_STATES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (op_valid),
        .start_kind  (dec_kind),
        .busy        (busy),
        .tstate      (tstate),
        .last        (xchg_done),
        .commit_pair (commit_pair),
        .commit_accf (commit_accf)
    );

    xchg_banks #(
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W)
    ) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_acc_en   (wr_acc_en),
        .wr_acc_data (wr_acc_data),
        .wr_flg_en   (wr_flg_en),
        .wr_flg_data (wr_flg_data),
        .wr_px_en    (wr_px_en),
        .wr_px_data  (wr_px_data),
        .wr_py_en    (wr_py_en),
        .wr_py_data  (wr_py_data),
        .flip_pair   (commit_pair),
        .flip_accf   (commit_accf),
        .acc         (acc),
        .flags       (flags),
        .ptr_x       (ptr_x),
        .ptr_y       (ptr_y)
    );

endmodule

// File: rtl/regbank_xchg_chk.sv
module regbank_xchg_chk #(
    parameter int         DATA_W   = 8,
    parameter int         PTR_W    = 16,
    parameter int         OP_W     = 8,
    parameter int         T_STATES = 4,
    parameter logic [7:0] OPC_PAIR = 8'hEB,
    parameter logic [7:0] OPC_ACCF = 8'h08,
    localparam int        TCW      = (T_STATES > 1) ? $clog2(T_STATES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic              wr_acc_en,
    input logic [DATA_W-1:0] wr_acc_data,
    input logic              wr_flg_en,
    input logic [DATA_W-1:0] wr_flg_data,
    input logic              wr_px_en,
    input logic [PTR_W-1:0]  wr_px_data,
    input logic              wr_py_en,
    input logic [PTR_W-1:0]  wr_py_data,
    input logic [DATA_W-1:0] acc,
    input logic [DATA_W-1:0] flags,
    input logic [PTR_W-1:0]  ptr_x,
    input logic [PTR_W-1:0]  ptr_y,
    input logic              busy,
    input logic [TCW-1:0]    tstate,
    input logic              xchg_done
);

    localparam logic [TCW-1:0] T_LAST = TCW'(T_STATES - 1);

    logic is_pair_op, is_accf_op, accepted, any_wr, ptr_wr, af_wr;
    logic pend_pair_q, pend_accf_q;

    assign is_pair_op = (op_code == OP_W'(OPC_PAIR));
    assign is_accf_op = (op_code == OP_W'(OPC_ACCF));
    assign accepted   = op_valid && !busy && (is_pair_op || is_accf_op);
    assign ptr_wr     = wr_px_en || wr_py_en;
    assign af_wr      = wr_acc_en || wr_flg_en;
    assign any_wr     = ptr_wr || af_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_pair_q <= 1'b0;
            pend_accf_q <= 1'b0;
        end else if (accepted) begin
            pend_pair_q <= is_pair_op;
            pend_accf_q <= is_accf_op;
        end
    end

    a_r1_idle_tstate: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tstate == '0);

    a_r2_pair_swaps: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_done && pend_pair_q && !ptr_wr |=>
            ptr_x == $past(ptr_y) && ptr_y == $past(ptr_x));

    a_r2_pair_keeps_af: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_done && pend_pair_q && !af_wr |=> $stable(acc) && $stable(flags));

    a_r3_accf_keeps_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_done && pend_accf_q && !ptr_wr |=> $stable(ptr_x) && $stable(ptr_y));

    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> busy && tstate == '0);

    a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
        busy && tstate != T_LAST |=> busy && tstate == $past(tstate) + TCW'(1));

    a_r4_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_done |-> busy && tstate == T_LAST);

    a_r4_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_done |=> !busy);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !xchg_done && !any_wr |=>
            $stable(acc) && $stable(flags) && $stable(ptr_x) && $stable(ptr_y));

    a_r8_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !busy && !is_pair_op && !is_accf_op |=> !busy);

endmodule

bind regbank_xchg regbank_xchg_chk #(
    .DATA_W   (DATA_W),
    .PTR_W    (PTR_W),
    .OP_W     (OP_W),
    .T_STATES (T_STATES),
    .OPC_PAIR (OPC_PAIR),
    .OPC_ACCF (OPC_ACCF)
) u_chk (.*);

// File: tb/regbank_xchg_test.sv
`timescale 1ns/1ps
module regbank_xchg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        wr_acc_en = 1'b0, wr_flg_en = 1'b0, wr_px_en = 1'b0, wr_py_en = 1'b0;
    logic [7:0]  wr_acc_data = '0, wr_flg_data = '0;
    logic [15:0] wr_px_data = '0, wr_py_data = '0;
    logic [7:0]  acc, flags;
    logic [15:0] ptr_x, ptr_y;
    logic        busy, xchg_done;
    logic [1:0]  tstate;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference model of the requirements: two copies per register, two selects.
    logic [7:0]  m_acc [2];
    logic [7:0]  m_flg [2];
    logic [15:0] m_ptr [2];
    logic        m_sa, m_sp;

    always #2.5 clk = ~clk;

    regbank_xchg uut (.*);

    // {op, acc, flg, px, py}
    localparam logic [55:0] VEC [10] = '{
        {8'h08, 8'h11, 8'h81, 16'h1000, 16'h2000},
        {8'h08, 8'h22, 8'h42, 16'h1001, 16'h2001},
        {8'hEB, 8'h33, 8'hC3, 16'hA5A5, 16'h5A5A},
        {8'h08, 8'h44, 8'h04, 16'h3000, 16'h4000},
        {8'hEB, 8'h55, 8'h15, 16'hBEEF, 16'hCAFE},
        {8'h00, 8'h66, 8'h26, 16'h0101, 16'h0202},
        {8'hEA, 8'h77, 8'h37, 16'h0303, 16'h0404},
        {8'h08, 8'h88, 8'hFF, 16'hFFFF, 16'h0000},
        {8'hEB, 8'h99, 8'h00, 16'h1234, 16'h5678},
        {8'h09, 8'hAA, 8'h5A, 16'h8000, 16'h0001}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " acc"},   {8'h00, acc},   {8'h00, m_acc[m_sa]});
        chk({req, " flags"}, {8'h00, flags}, {8'h00, m_flg[m_sa]});
        chk({req, " ptr_x"}, ptr_x, m_ptr[m_sp]);
        chk({req, " ptr_y"}, ptr_y, m_ptr[~m_sp]);
    endtask

    task automatic write_all(input logic [7:0] a, input logic [7:0] f,
                             input logic [15:0] px, input logic [15:0] py);
        @(negedge clk);
        wr_acc_en = 1; wr_acc_data = a;
        wr_flg_en = 1; wr_flg_data = f;
        wr_px_en = 1;  wr_px_data = px;
        wr_py_en = 1;  wr_py_data = py;
        @(negedge clk);
        wr_acc_en = 0; wr_flg_en = 0; wr_px_en = 0; wr_py_en = 0;
        m_acc[m_sa] = a; m_flg[m_sa] = f;
        m_ptr[m_sp] = px; m_ptr[~m_sp] = py;
    endtask

    // Offers op for one edge; returns at the negedge after that edge.
    task automatic offer(input logic [7:0] op);
        @(negedge clk);
        op_valid = 1; op_code = op;
        @(negedge clk);
        op_valid = 0; op_code = 8'h00;
    endtask

    function automatic void model_op(input logic [7:0] op);
        if (op == 8'hEB) m_sp = ~m_sp;
        else if (op == 8'h08) m_sa = ~m_sa;
    endfunction

    // Offer and wait out the cycle; returns with outputs settled after it.
    task automatic run_op(input logic [7:0] op);
        offer(op);
        repeat (4) @(negedge clk);
        model_op(op);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_acc = '{8'h00, 8'h00}; m_flg = '{8'h00, 8'h00};
        m_ptr = '{16'h0, 16'h0}; m_sa = 0; m_sp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk_outputs("R1 reset");
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 tstate", {14'd0, tstate}, 16'd0);

        // R4 timing of one exchange, with R5 hold during it
        write_all(8'hC1, 8'h9E, 16'h0ABC, 16'h0DEF);
        offer(8'hEB);
        for (int t = 0; t < 4; t++) begin
            chk("R4 busy", {15'd0, busy}, 16'd1);
            chk("R4 tstate", {14'd0, tstate}, 16'(t));
            chk("R4 done", {15'd0, xchg_done}, 16'(t == 3));
            chk_outputs("R5 hold");
            @(negedge clk);
        end
        model_op(8'hEB);
        chk("R4 busy end", {15'd0, busy}, 16'd0);
        chk_outputs("R2 pair swap");

        // Vector walk: R2, R3, R6, R8
        foreach (VEC[i]) begin
            write_all(VEC[i][47:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0]);
            run_op(VEC[i][55:48]);
            if (VEC[i][55:48] == 8'hEB)      chk_outputs("R2 vec");
            else if (VEC[i][55:48] == 8'h08) chk_outputs("R3 R6 vec");
            else begin
                chk("R8 busy", {15'd0, busy}, 16'd0);
                chk_outputs("R8 vec");
            end
        end

        // R8: non-exchange opcode starts no cycle
        offer(8'hED);
        chk("R8 no start", {15'd0, busy}, 16'd0);
        chk_outputs("R8 other op");

        // R8: opcode offered while busy is ignored
        offer(8'hEB);
        @(negedge clk);
        op_valid = 1; op_code = 8'h08;
        @(negedge clk);
        op_valid = 0; op_code = 8'h00;
        repeat (2) @(negedge clk);
        model_op(8'hEB);
        chk("R8 busy after", {15'd0, busy}, 16'd0);
        chk_outputs("R8 during busy");

        // R6: write after accf swap lands in alternate; R7 restores
        write_all(8'h3C, 8'hC3, 16'h1111, 16'h2222);
        run_op(8'h08);
        write_all(8'h5A, 8'hA5, 16'h1111, 16'h2222);
        chk("R6 alt acc", {8'h00, acc}, 16'h005A);
        run_op(8'h08);
        chk("R6 main acc", {8'h00, acc}, 16'h003C);
        chk("R6 main flags", {8'h00, flags}, 16'h00C3);
        run_op(8'h08);
        chk("R6 alt back", {8'h00, acc}, 16'h005A);

        // R7: double pair exchange restores
        run_op(8'hEB);
        run_op(8'hEB);
        chk("R7 ptr_x", ptr_x, 16'h1111);
        chk("R7 ptr_y", ptr_y, 16'h2222);
        chk_outputs("R7 double");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule